// File: doc/BRIEF.md
# Trigger Delay and Phase Tagger

This block takes a trigger that arrives with no fixed timing relation to the fast clock and brings it into that clock's domain. After a programmable number of fast-clock cycles it issues a delayed trigger one cycle wide. The fast clock runs at eight times a common reference clock, and the reference arrives as a sampled input. With every accepted trigger the block also records a 3-bit phase tag: the position of the trigger within the current reference period, counted in fast-clock edges since the last reference rising edge.

The tag is meant to leave with the event data. The same tag is also made at the place where the trigger starts, so the two can be compared offline. A mismatch shows that one side sampled the trigger right on its edge. A small register port sets the coarse delay and holds a fine-step value, which is passed on to an external clock phase shifter. The port also reports two sticky error flags.

Top module: `trig_delay_tagger`

## Requirements
- R1: A rising edge on `trig_in` that is set up before fast-clock edge k produces `trig_out` high for the cycle that follows edge k+2+D, where D is the coarse delay latched when the trigger was accepted. D = 0 issues the pulse in the cycle right after the cycle in which the synchronised trigger was detected.
- R2: `trig_out` is high for exactly one cycle per accepted trigger. A `trig_in` that stays high produces only one pulse.
- R3: The reference phase counter is 3 bits wide and is cleared by each reference rising edge. On an accepted trigger whose edge is set up before fast edge k, `tag_out` equals (k − j) mod 8, where j is the fast edge before which the latest reference rising edge was set up. The tag shows at the same edge as `tag_valid`, which is edge k+2.
- R4: Once `tag_valid` is high, `tag_valid` and `tag_out` are held unchanged until `tag_ack` is sampled high. That edge clears `tag_valid`, unless a new tag is captured at the same edge.
- R5: A trigger detected while a delay is still counting is ignored: it causes no `trig_out` pulse. It sets status bit 0 (overlap).
- R6: A trigger accepted while a tag is still pending and unacknowledged leaves the pending tag unchanged. It sets status bit 1 (tag lost). The delayed pulse is still issued.
- R7: Status bits are sticky. Writing address 2 with a 1 in a bit position clears that bit. A set event in the same cycle wins over the clear.
- R8: A write to the coarse delay while a delay is counting does not change that delay. The new value applies from the next accepted trigger.
- R9: Register map, read combinationally on `reg_rdata` with unused bits zero: address 0 holds the coarse delay in bits [DLY_W-1:0]; address 1 holds the fine step in bits [FINE_W-1:0], and `fine_step` always shows this value; address 2 holds status, with overlap in bit 0 and tag lost in bit 1.
- R10: After reset, `trig_out` and `tag_valid` are low and all three registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, eight times the reference rate |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger input |
| ref_in | input | 1 | Common reference clock, sampled as data |
| tag_ack | input | 1 | Readout acknowledge of the pending tag |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| trig_out | output | 1 | Delayed trigger pulse, one cycle |
| tag_out | output | 3 | Captured phase tag |
| tag_valid | output | 1 | Phase tag pending |
| fine_step | output | FINE_W | Programmed fine phase step |

## Verification
A wrong count in the coarse counter shows up at once as a `trig_out` pulse on the wrong cycle. The scoreboard compares the cycle of every pulse with the cycle it expects. A slipped reference phase counter gives a wrong `tag_out` two cycles after the trigger, at every phase offset the bench sweeps. A stuck busy state or a missing overlap gate shows up within one delay window, as either no pulse or a surplus pulse, and as a status flag that reads back wrong.

// File: rtl/tdt_pkg.sv
// Shared types for the trigger delay and phase tagger.
// Assumes a 2-bit register address space.
package tdt_pkg;

    typedef enum logic [1:0] {
        ADDR_COARSE = 2'd0,
        ADDR_FINE   = 2'd1,
        ADDR_STAT   = 2'd2,
        ADDR_NONE   = 2'd3
    } tdt_addr_e;

    // Sticky error flags, bit 0 = overlap, bit 1 = tag lost.
    typedef struct packed {
        logic lost;
        logic ovl;
    } tdt_stat_t;

endpackage

// File: rtl/tdt_edge_sync.sv
// Multi-flop synchroniser followed by a rising-edge detector.
// Produces a single-cycle pulse per low-to-high change of async_in.
// Assumes async_in stays at each level for at least one clock period.
module tdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);

    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the input through the synchroniser chain and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    // Rising edge of the synchronised level.
    assign rise_o = chain[STAGES-1] & ~last;

endmodule

// File: rtl/tdt_phase.sv
// Reference phase counter and phase tag capture.
// The counter gives the number of fast edges since the last reference rise.
// A tag is captured on an accepted trigger and held until acknowledged.
module tdt_phase #(
    parameter int PH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_rise,
    input  logic            trig_acc,
    input  logic            ack,
    output logic [PH_W-1:0] tag_o,
    output logic            valid_o,
    output logic            lost_o
);

    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] ph_now;
    logic            cap;

    // Phase of the current cycle: zero on a reference rise, else one more.
    assign ph_now = ref_rise ? '0 : cnt + PH_W'(1);
    assign cap    = trig_acc && (!valid_o || ack);
    assign lost_o = trig_acc && valid_o && !ack;

    // Free-running phase counter, realigned by the reference.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= ph_now;
    end

    // Capture the tag on a trigger; hold it until the readout acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o   <= '0;
            valid_o <= 1'b0;
        end else if (cap) begin
            tag_o   <= ph_now;
            valid_o <= 1'b1;
        end else if (ack) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/tdt_coarse.sv
// Coarse delay counter. On start it latches the delay value and issues a
// one-cycle fire pulse after that many further cycles (zero: next cycle).
// Assumes start is only raised while busy_o is low.
module tdt_coarse #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] dly,
    output logic             busy_o,
    output logic             fire_o
);

    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] tgt;

    // Count up to the latched delay, then fire and go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tgt    <= '0;
            busy_o <= 1'b0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (busy_o) begin
                if (cnt == tgt) begin
                    busy_o <= 1'b0;
                    fire_o <= 1'b1;
                end else begin
                    cnt <= cnt + DLY_W'(1);
                end
            end else if (start) begin
                if (dly == '0) begin
                    fire_o <= 1'b1;
                end else begin
                    busy_o <= 1'b1;
                    cnt    <= DLY_W'(1);
                    tgt    <= dly;
                end
            end
        end
    end

endmodule

// File: rtl/tdt_regs.sv
// Register file: coarse delay, fine step and sticky status.
// Reads are combinational; writes take effect at the next edge.
module tdt_regs
    import tdt_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int DLY_W  = 6,
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              ovl_set,
    input  logic              lost_set,
    output logic [DLY_W-1:0]  coarse_o,
    output logic [FINE_W-1:0] fine_o,
    output tdt_stat_t         stat_o
);

    tdt_addr_e sel;
    logic      stat_wr;

    assign sel     = tdt_addr_e'(addr);
    assign stat_wr = we && (sel == ADDR_STAT);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_o <= '0;
            fine_o   <= '0;
        end else if (we) begin
            if (sel == ADDR_COARSE) coarse_o <= wdata[DLY_W-1:0];
            if (sel == ADDR_FINE)   fine_o   <= wdata[FINE_W-1:0];
        end
    end

    // Sticky flags: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= '0;
        end else begin
            if (ovl_set)                    stat_o.ovl  <= 1'b1;
            else if (stat_wr && wdata[0])   stat_o.ovl  <= 1'b0;
            if (lost_set)                   stat_o.lost <= 1'b1;
            else if (stat_wr && wdata[1])   stat_o.lost <= 1'b0;
        end
    end

    // Read multiplexer with zero extension.
    always_comb begin
        rdata = '0;
        case (sel)
            ADDR_COARSE: rdata[DLY_W-1:0]  = coarse_o;
            ADDR_FINE:   rdata[FINE_W-1:0] = fine_o;
            ADDR_STAT:   rdata[1:0]        = stat_o;
            default:     rdata             = '0;
        endcase
    end

endmodule

// File: rtl/trig_delay_tagger.sv
// Trigger delay and phase tagger top level.
// Synchronises an asynchronous trigger and a sampled reference into the fast
// domain, delays the trigger by a programmable cycle count and tags it with
// its phase inside the reference period. Assumes the fast clock is eight
// times the reference, so a 3-bit tag covers one reference period.
module trig_delay_tagger #(
    parameter int REG_W   = 16,
    parameter int DLY_W   = 6,
    parameter int FINE_W  = 8,
    parameter int SYNC_N  = 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              ref_in,
    input  logic              tag_ack,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              trig_out,
    output logic [2:0]        tag_out,
    output logic              tag_valid,
    output logic [FINE_W-1:0] fine_step
);

    import tdt_pkg::*;

    localparam int PH_W = 3;

    logic             trig_det;
    logic             ref_rise;
    logic             busy;
    logic             accept;
    logic             lost_pulse;
    logic [DLY_W-1:0] coarse;
    tdt_stat_t        stat;
    logic             ovl_flag;
    logic             lost_flag;

    // A trigger is only taken while no delay is counting.
    assign accept    = trig_det && !busy;
    assign ovl_flag  = stat.ovl;
    assign lost_flag = stat.lost;

    tdt_edge_sync #(.STAGES(SYNC_N)) u_trig_sync (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise_o   (trig_det)
    );

    tdt_edge_sync #(.STAGES(SYNC_N)) u_ref_sync (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .async_in (ref_in),
        .rise_o   (ref_rise)
    );

    tdt_phase #(.PH_W(PH_W)) u_phase (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .ref_rise (ref_rise),
        .trig_acc (accept),
        .ack      (tag_ack),
        .tag_o    (tag_out),
        .valid_o  (tag_valid),
        .lost_o   (lost_pulse)
    );

    tdt_coarse #(.DLY_W(DLY_W)) u_coarse (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .start  (accept),
        .dly    (coarse),
        .busy_o (busy),
        .fire_o (trig_out)
    );

    tdt_regs #(.REG_W(REG_W), .DLY_W(DLY_W), .FINE_W(FINE_W)) u_regs (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ovl_set  (trig_det && busy),
        .lost_set (lost_pulse),
        .coarse_o (coarse),
        .fine_o   (fine_step),
        .stat_o   (stat)
    );

endmodule

// File: rtl/tdt_checker.sv
// Protocol checker for the trigger delay and phase tagger, bound to the top.
module tdt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_out,
    input logic       tag_valid,
    input logic [2:0] tag_out,
    input logic       tag_ack,
    input logic       trig_det,
    input logic       busy,
    input logic       ovl_flag,
    input logic       lost_flag,
    input logic       stat_clr_ovl
);

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    assert_fire_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> ($past(busy) || $past(trig_det)));

    assert_tag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !tag_ack) |=> (tag_valid && $stable(tag_out)));

    assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig_det) |=> ovl_flag);

    assert_tag_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !tag_ack && trig_det && !busy) |=> lost_flag);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_flag && !stat_clr_ovl) |=> ovl_flag);

endmodule

bind trig_delay_tagger tdt_checker u_chk (
    .clk          (clk_fast),
    .rst_n        (rst_n),
    .trig_out     (trig_out),
    .tag_valid    (tag_valid),
    .tag_out      (tag_out),
    .tag_ack      (tag_ack),
    .trig_det     (trig_det),
    .busy         (busy),
    .ovl_flag     (ovl_flag),
    .lost_flag    (lost_flag),
    .stat_clr_ovl (reg_we && (reg_addr == 2'd2) && reg_wdata[0])
);

// File: tb/trig_delay_tagger_test.sv
// Scoreboard bench: the driver pushes expected pulse cycles and tags,
// the monitor pops and compares them as the design produces results.
module trig_delay_tagger_test;

    localparam int REG_W  = 16;
    localparam int DLY_W  = 6;
    localparam int FINE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_in = 1'b0;
    logic              ref_in = 1'b0;
    logic              mon_ack = 1'b0;
    logic              drv_ack = 1'b0;
    logic              tag_ack;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              trig_out;
    logic [2:0]        tag_out;
    logic              tag_valid;
    logic [FINE_W-1:0] fine_step;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int cur_dly = 0;
    bit auto_ack = 1'b1;
    bit tv_q = 1'b0;
    bit done = 1'b0;

    int fire_q[$];
    int tagv_q[$];
    int tagc_q[$];

    assign tag_ack = mon_ack | drv_ack;

    trig_delay_tagger #(.REG_W(REG_W), .DLY_W(DLY_W), .FINE_W(FINE_W)) uut (
        .clk_fast  (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .ref_in    (ref_in),
        .tag_ack   (tag_ack),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_out  (trig_out),
        .tag_out   (tag_out),
        .tag_valid (tag_valid),
        .fine_step (fine_step)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference: rising edge set up before every fast edge that is a multiple of 8.
    always @(negedge clk) ref_in <= (((cyc + 1) % 8) < 4);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare delayed pulses and tag captures with the scoreboard.
    always @(negedge clk) begin
        mon_ack = 1'b0;
        if (rst_n) begin
            if (trig_out) begin
                if (fire_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected trig_out", cyc, -1);
                end else begin
                    int e;
                    e = fire_q.pop_front();
                    chk(cyc == e, "R1 trig_out cycle", cyc, e);
                end
            end
            if (tag_valid && !tv_q) begin
                if (tagv_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected tag_valid", cyc, -1);
                end else begin
                    int ev;
                    int ec;
                    ev = tagv_q.pop_front();
                    ec = tagc_q.pop_front();
                    chk(int'(tag_out) == ev, "R3 tag value", int'(tag_out), ev);
                    chk(cyc == ec, "R3 tag cycle", cyc, ec);
                end
                mon_ack = auto_ack;
            end
            tv_q = tag_valid;
        end
    end

    // Driver: raise the trigger now (called just after a falling edge).
    task automatic pulse(input bit push_fire, input bit push_tag, input int hold,
                         output int tagv);
        int c;
        c = cyc;
        trig_in = 1'b1;
        tagv = (c + 1) % 8;
        if (push_fire) fire_q.push_back(c + 3 + cur_dly);
        if (push_tag) begin
            tagv_q.push_back(tagv);
            tagc_q.push_back(c + 3);
        end
        repeat (hold) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 2'(a);
        reg_wdata = REG_W'(d);
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 0) cur_dly = d;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 2'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic at_phase(input int p);
        do @(negedge clk); while (((cyc + 1) % 8) != p);
    endtask

    // Watchdog.
    initial begin
        #1500000;
        if (!done) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        int ta;
        int dl[4];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R10: reset state.
        chk(trig_out == 1'b0, "R10 trig_out low", int'(trig_out), 0);
        chk(tag_valid == 1'b0, "R10 tag_valid low", int'(tag_valid), 0);
        for (int a = 0; a < 3; a++) begin
            rd(a, v);
            chk(v == 0, "R10 register reset", v, 0);
        end

        // R9: fine step readback and output.
        wr(1, 137);
        rd(1, v);
        chk(v == 137, "R9 fine readback", v, 137);
        chk(int'(fine_step) == 137, "R9 fine_step port", int'(fine_step), 137);
        wr(0, 45);
        rd(0, v);
        chk(v == 45, "R9 coarse readback", v, 45);
        wr(1, 300);
        rd(1, v);
        chk(v == 44, "R9 fine width truncation", v, 44);

        // R1, R3: every phase at several delays.
        dl[0] = 0; dl[1] = 1; dl[2] = 5; dl[3] = 63;
        for (int i = 0; i < 4; i++) begin
            wr(0, dl[i]);
            for (int p = 0; p < 8; p++) begin
                at_phase((p + 3 * i) % 8);
                pulse(1'b1, 1'b1, 3, ta);
                repeat (75) @(negedge clk);
            end
        end

        // R2: held trigger gives one pulse.
        wr(0, 3);
        @(negedge clk);
        pulse(1'b1, 1'b1, 40, ta);
        repeat (20) @(negedge clk);
        chk(fire_q.size() == 0, "R2 one pulse for held trigger", fire_q.size(), 0);

        // R5: trigger during a running delay is ignored.
        wr(0, 20);
        @(negedge clk);
        pulse(1'b1, 1'b1, 2, ta);
        repeat (4) @(negedge clk);
        pulse(1'b0, 1'b0, 2, ta);
        repeat (30) @(negedge clk);
        chk(fire_q.size() == 0, "R5 ignored trigger gave no pulse", fire_q.size(), 0);
        rd(2, v);
        chk(v == 1, "R5 overlap flag set", v, 1);

        // R7: sticky until write-one-to-clear.
        wr(2, 2);
        rd(2, v);
        chk(v == 1, "R7 clearing other bit keeps overlap", v, 1);
        wr(2, 1);
        rd(2, v);
        chk(v == 0, "R7 overlap cleared", v, 0);

        // R8: coarse write mid-count affects only the next trigger.
        wr(0, 10);
        @(negedge clk);
        pulse(1'b1, 1'b1, 3, ta);
        wr(0, 2);
        repeat (20) @(negedge clk);
        chk(fire_q.size() == 0, "R8 running delay kept", fire_q.size(), 0);
        @(negedge clk);
        pulse(1'b1, 1'b1, 3, ta);
        repeat (10) @(negedge clk);
        chk(fire_q.size() == 0, "R8 new delay applied", fire_q.size(), 0);

        // R4, R6: pending tag held, second tag lost.
        wr(0, 0);
        auto_ack = 1'b0;
        @(negedge clk);
        pulse(1'b1, 1'b1, 3, ta);
        repeat (10) @(negedge clk);
        pulse(1'b1, 1'b0, 3, v);
        repeat (30) @(negedge clk);
        chk(tag_valid == 1'b1, "R4 tag_valid held", int'(tag_valid), 1);
        chk(int'(tag_out) == ta, "R6 pending tag kept", int'(tag_out), ta);
        chk(fire_q.size() == 0, "R6 pulse still issued", fire_q.size(), 0);
        rd(2, v);
        chk(v == 2, "R6 lost flag set", v, 2);
        @(negedge clk);
        drv_ack = 1'b1;
        @(negedge clk);
        drv_ack = 1'b0;
        chk(tag_valid == 1'b0, "R4 ack clears tag_valid", int'(tag_valid), 0);
        auto_ack = 1'b1;
        wr(2, 3);
        rd(2, v);
        chk(v == 0, "R7 lost cleared", v, 0);

        repeat (10) @(negedge clk);
        chk(fire_q.size() == 0, "R1 all pulses seen", fire_q.size(), 0);
        chk(tagv_q.size() == 0, "R3 all tags seen", tagv_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule